// File: doc/BRIEF.md
# Serial Port Master Shift Engine

This block runs a serial port as a synchronous master shift engine when its control byte selects that mode. It reads the same control byte the UART modes use. In this mode, three low bits that carry character size and clock polarity for the UART modes are reused as bit order, clock phase and clock polarity. The parity and stop-bit fields are masked away and cannot influence a transfer.

A client offers an 8-bit word together with a one-cycle start strobe. The block latches the word and the timing settings, and then advances one shift-clock edge per half-period tick from an external divider. It drives the shift clock and the outgoing data line and samples the incoming data line. One clock after the sixteenth edge it presents the received byte with a one-cycle done pulse. Chip-select, baud generation and any queueing belong to the surrounding logic.

Top module: `usart_spi_master`

## Requirements
- R1: The engine is enabled only when control bits [7:6] equal 2'b11. With any other value a start strobe is ignored and `busy` stays low.
- R2: A start strobe seen while idle and enabled raises `busy` on the next clock. The bit order and clock phase in force for that transfer are the control byte values in that same cycle.
- R3: Control bit 2 selects bit order. With 1 the least significant bit is shifted first and with 0 the most significant bit is shifted first. The same order applies to both directions, so looping `mosi` back to `miso` returns the sent byte.
- R4: Between transfers `sclk` follows control bit 0, one clock late. During a transfer each `half_tick` toggles `sclk`, for exactly 16 toggles, so the clock ends at its idle level.
- R5: With control bit 1 at 0, the first data bit is on `mosi` from the cycle after the start, before the first clock edge. `miso` is sampled on edges 1, 3, …, 15 and `mosi` changes on edges 2, 4, …, 14.
- R6: With control bit 1 at 1, the first data bit is held through edge 1. `mosi` changes on edges 3, 5, …, 15 and `miso` is sampled on edges 2, 4, …, 16.
- R7: Control bits [5:3] have no effect on the clock, the data line or the received byte.
- R8: A start strobe that arrives while `busy` is high is ignored. The transfer in progress and its data are not disturbed.
- R9: On the clock after the sixteenth edge, `done` is high for exactly one cycle and `rx_data` carries the received byte. `rx_data` holds that byte until the next `done`.
- R10: After reset `sclk`, `mosi`, `busy`, `done` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_reg | input | 8 | Current control byte (mode, reserved frame fields, order/phase/polarity) |
| half_tick | input | 1 | One-cycle pulse per half shift-clock period |
| start | input | 1 | Begin a transfer with `tx_data` |
| tx_data | input | 8 | Word to send |
| miso | input | 1 | Incoming serial data |
| sclk | output | 1 | Shift clock |
| mosi | output | 1 | Outgoing serial data |
| busy | output | 1 | Transfer in progress |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
All four phase/polarity combinations run with both bit orders, which separates a wrong sampling edge from a wrong launch edge and from a reversed bit order. A loopback pattern (`miso` tied to `mosi`) must return each word unchanged. A pseudo-random `miso` stream exposes samples taken on the wrong edge, which loopback alone would hide. Ticks arrive both on every clock and spread apart, to catch off-by-one edge counting. Extra patterns cover toggled reserved bits, a start strobe during a transfer and a start strobe in a non-master mode; these show that ignored inputs leave the outputs untouched.

// File: rtl/usart_spi_pkg.sv
// Package: shared types for the serial-port master shift engine.
// Assumes the control byte layout used by all serial-port modes.
package usart_spi_pkg;

    // Operating mode carried in control bits [7:6]
    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_SYNC  = 2'b01,
        MODE_RSVD  = 2'b10,
        MODE_SPIM  = 2'b11
    } port_mode_e;

    // Timing settings relevant to the master shift mode
    typedef struct packed {
        logic lsb_first;
        logic cpha;
        logic cpol;
    } shift_cfg_t;

endpackage

// File: rtl/spi_ctrl_decode.sv
// Module: spi_ctrl_decode
// Reads the shared control byte and extracts the master-shift view of it.
// Reserved frame fields (parity, stop bits) are masked before any use, so
// they cannot reach the datapath. Purely combinational.
module spi_ctrl_decode
    import usart_spi_pkg::*;
#(
    parameter int CTRL_W   = 8,
    parameter int MODE_LSB = 6,
    parameter int ORD_BIT  = 2,
    parameter int PHA_BIT  = 1,
    parameter int POL_BIT  = 0
) (
    input  logic [CTRL_W-1:0] ctrl,
    output logic              active,
    output shift_cfg_t        cfg
);
    localparam logic [CTRL_W-1:0] KEEP_MASK =
        (CTRL_W'(3) << MODE_LSB) | (CTRL_W'(1) << ORD_BIT) |
        (CTRL_W'(1) << PHA_BIT)  | (CTRL_W'(1) << POL_BIT);

    logic [CTRL_W-1:0] spi_view;
    port_mode_e        mode;

    // Drop reserved fields and decode mode and timing bits
    always_comb begin
        spi_view      = ctrl & KEEP_MASK;
        mode          = port_mode_e'(spi_view[MODE_LSB +: 2]);
        active        = (mode == MODE_SPIM);
        cfg.lsb_first = spi_view[ORD_BIT];
        cfg.cpha      = spi_view[PHA_BIT];
        cfg.cpol      = spi_view[POL_BIT];
    end
endmodule

// File: rtl/spi_edge_seq.sv
// Module: spi_edge_seq
// Counts shift-clock edges, drives the shift clock and tells the shifter
// when to sample and when to launch the next bit. One edge per half_tick
// while busy. Assumes load is only asserted while idle.
module spi_edge_seq #(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic half_tick,
    input  logic idle_pol,
    input  logic cpha,
    output logic sclk,
    output logic busy,
    output logic sample,
    output logic launch,
    output logic fin
);
    localparam int EDGES = 2 * WORD_W;
    localparam int CW    = $clog2(EDGES + 1);

    logic [CW-1:0] edge_cnt;
    logic [CW-1:0] nxt;
    logic          step;
    logic          samp_edge;
    logic          last;

    // Classify the edge that the coming tick will produce
    always_comb begin
        nxt       = edge_cnt + CW'(1);
        step      = busy && half_tick;
        samp_edge = nxt[0] ^ cpha;
        sample    = step && samp_edge;
        launch    = step && !samp_edge &&
                    (nxt != CW'(1)) && (nxt != CW'(EDGES));
        last      = step && (nxt == CW'(EDGES));
    end

    // Edge counter, shift clock and busy state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            edge_cnt <= '0;
            sclk     <= 1'b0;
            fin      <= 1'b0;
        end else begin
            fin <= last;
            if (!busy) begin
                sclk     <= idle_pol;
                edge_cnt <= '0;
                if (load) busy <= 1'b1;
            end else if (half_tick) begin
                sclk     <= ~sclk;
                edge_cnt <= nxt;
                if (last) busy <= 1'b0;
            end
        end
    end

    // R4
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !half_tick) |=> $stable(sclk));

    // R8
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !half_tick) |=> busy);
endmodule

// File: rtl/spi_shifter.sv
// Module: spi_shifter
// Holds the outgoing and incoming shift registers. The outgoing word is
// reordered at load so the shifter always emits from its top bit; the
// incoming word is reordered once at the end. Assumes sample and launch
// are never high together.
module spi_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              lsb_now,
    input  logic              lsb_held,
    input  logic              sample,
    input  logic              launch,
    input  logic              fin,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_data,
    output logic              done
);
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] tx_ord;

    function automatic logic [WORD_W-1:0] flip(input logic [WORD_W-1:0] v);
        for (int i = 0; i < WORD_W; i++) flip[i] = v[WORD_W-1-i];
    endfunction

    // Put the first bit to be sent at the top
    always_comb tx_ord = lsb_now ? flip(tx_data) : tx_data;

    // Outgoing shift path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            mosi  <= 1'b0;
        end else if (load) begin
            mosi  <= tx_ord[WORD_W-1];
            tx_sr <= tx_ord << 1;
        end else if (launch) begin
            mosi  <= tx_sr[WORD_W-1];
            tx_sr <= tx_sr << 1;
        end
    end

    // Incoming shift path
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_sr <= '0;
        else if (sample) rx_sr <= {rx_sr[WORD_W-2:0], miso};
    end

    // Publish the received word with a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= fin;
            if (fin) rx_data <= lsb_held ? flip(rx_sr) : rx_sr;
        end
    end

    // R5
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !launch) |=> $stable(mosi));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(rx_data));
endmodule

// File: rtl/usart_spi_master.sv
// Module: usart_spi_master (top)
// Serial port operated as a master shift engine. Decodes the shared control
// byte, accepts a start while idle, latches order and phase, and wires the
// edge sequencer to the shifter. Assumes half_tick comes from an external
// divider and is at most one pulse per clock.
module usart_spi_master
    import usart_spi_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_reg,
    input  logic              half_tick,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic [WORD_W-1:0] rx_data,
    output logic              done
);
    logic       active;
    shift_cfg_t cfg_now;
    logic       load;
    logic       cpha_q;
    logic       lsb_q;
    logic       sample;
    logic       launch;
    logic       fin;

    spi_ctrl_decode #(.CTRL_W(CTRL_W)) dec_i (
        .ctrl   (ctrl_reg),
        .active (active),
        .cfg    (cfg_now)
    );

    // Accept a start only while idle and in master shift mode
    always_comb load = start && active && !busy;

    // Latch per-transfer order and phase at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpha_q <= 1'b0;
            lsb_q  <= 1'b0;
        end else if (load) begin
            cpha_q <= cfg_now.cpha;
            lsb_q  <= cfg_now.lsb_first;
        end
    end

    spi_edge_seq #(.WORD_W(WORD_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .half_tick (half_tick),
        .idle_pol  (cfg_now.cpol),
        .cpha      (cpha_q),
        .sclk      (sclk),
        .busy      (busy),
        .sample    (sample),
        .launch    (launch),
        .fin       (fin)
    );

    spi_shifter #(.WORD_W(WORD_W)) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .tx_data  (tx_data),
        .lsb_now  (cfg_now.lsb_first),
        .lsb_held (lsb_q),
        .sample   (sample),
        .launch   (launch),
        .fin      (fin),
        .miso     (miso),
        .mosi     (mosi),
        .rx_data  (rx_data),
        .done     (done)
    );

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && active && !busy) |=> busy);

    // R1
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !active) |=> !busy);
endmodule

// File: tb/usart_spi_master_tb_top.sv
module usart_spi_master_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl_reg = 8'h06;
    logic       half_tick = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       miso = 1'b0;
    logic       sclk, mosi, busy, done;
    logic [7:0] rx_data;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_div = 1;
    bit loopback = 1'b0;
    bit tick_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usart_spi_master dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl_reg), .half_tick(half_tick),
        .start(start), .tx_data(tx_data), .miso(miso), .sclk(sclk),
        .mosi(mosi), .busy(busy), .rx_data(rx_data), .done(done)
    );

    // Behavioural reference model, advanced at each rising edge
    bit   m_busy, m_fin, m_done, m_sclk, m_mosi, m_cpha, m_lsb;
    bit [7:0] m_rx;
    int   m_edge;
    bit   txq[$];
    bit   rxq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_fin = 0; m_done = 0; m_sclk = 0; m_mosi = 0;
            m_rx = 0; m_edge = 0; txq.delete(); rxq.delete();
        end else begin
            m_done = m_fin;
            if (m_fin) begin
                for (int i = 0; i < 8; i++)
                    if (m_lsb) m_rx[i] = rxq[i]; else m_rx[7-i] = rxq[i];
            end
            m_fin = 0;
            if (!m_busy) begin
                m_sclk = ctrl_reg[0];
                if (start && ctrl_reg[7:6] == 2'b11) begin
                    m_busy = 1; m_edge = 0;
                    m_cpha = ctrl_reg[1]; m_lsb = ctrl_reg[2];
                    txq.delete(); rxq.delete();
                    for (int i = 0; i < 8; i++)
                        txq.push_back(m_lsb ? tx_data[i] : tx_data[7-i]);
                    m_mosi = txq.pop_front();
                end
            end else if (half_tick) begin
                m_edge++;
                m_sclk = ~m_sclk;
                if (((m_edge % 2) == 1) != m_cpha) rxq.push_back(miso);
                else if (m_edge != 1 && m_edge != 16) m_mosi = txq.pop_front();
                if (m_edge == 16) begin m_busy = 0; m_fin = 1; end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the rising edge
    initial forever begin
        @(negedge clk);
        if (!finished) begin
            chk(sclk == m_sclk, "R4 R5 R6 sclk", sclk, m_sclk);
            chk(mosi == m_mosi, "R3 R5 R6 R7 mosi", mosi, m_mosi);
            chk(busy == m_busy, "R1 R2 R8 busy", busy, m_busy);
            chk(done == m_done, "R9 done", done, m_done);
            chk(rx_data == m_rx, "R3 R7 R9 rx_data", rx_data, m_rx);
        end
    end

    // Tick divider and incoming data line stimulus
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            miso = loopback ? mosi : lfsr[0];
            if (tick_en && cnt >= tick_div - 1) begin half_tick = 1; cnt = 0; end
            else begin half_tick = 0; if (tick_en) cnt++; end
        end
    end

    task automatic xfer(input logic [7:0] c, input logic [7:0] d, output logic [7:0] got);
        @(negedge clk);
        ctrl_reg = c; tx_data = d; start = 1;
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (done) break;
        end
        got = rx_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got, got2;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(sclk == 0 && mosi == 0 && busy == 0 && done == 0 && rx_data == 0,
            "R10 reset", {sclk, mosi, busy, done}, 0);
        @(negedge clk); rst_n = 1; tick_en = 1;

        // R3 R5 R6: loopback in every mode and order, two tick rates
        for (int div = 1; div <= 3; div += 2) begin
            tick_div = div; loopback = 1;
            for (int m = 0; m < 8; m++) begin
                logic [7:0] w;
                w = 8'h5B ^ 8'(m * 37);
                xfer({2'b11, 3'b000, 3'(m)}, w, got);
                chk(got == w, "R3 loopback", got, w);
                repeat (3) @(negedge clk);
                // R4: idle level follows polarity
                chk(sclk == m[0], "R4 idle sclk", sclk, m[0]);
            end
        end

        // R5 R6: random incoming stream, model compares capture edges
        loopback = 0;
        for (int m = 0; m < 8; m++) begin
            xfer({2'b11, 3'b000, 3'(m)}, 8'hC3, got);
            repeat (2) @(negedge clk);
        end

        // R7: reserved bits toggled give the same loopback result
        loopback = 1; tick_div = 2;
        xfer(8'hC4, 8'h96, got);
        xfer(8'hFC, 8'h96, got2);
        chk(got == got2, "R7 reserved bits", got2, got);

        // R8: start mid-transfer ignored
        @(negedge clk);
        ctrl_reg = 8'hC1; tx_data = 8'h3C; start = 1;
        @(negedge clk); start = 0;
        repeat (6) @(negedge clk);
        tx_data = 8'hFF; ctrl_reg = 8'hC6; start = 1;
        @(negedge clk); start = 0; ctrl_reg = 8'hC1;
        for (int k = 0; k < 200 && !done; k++) @(negedge clk);
        chk(rx_data == 8'h3C, "R8 busy start ignored", rx_data, 8'h3C);

        // R1: non-master modes ignore start
        for (int md = 0; md < 3; md++) begin
            repeat (2) @(negedge clk);
            ctrl_reg = {2'(md), 6'b000110}; start = 1;
            @(negedge clk); start = 0;
            @(negedge clk);
            chk(busy == 0, "R1 mode gate", busy, 0);
        end

        // R2: settings written together with enable apply at once
        xfer(8'hC7, 8'h81, got);
        chk(got == 8'h81, "R2 same-write settings", got, 8'h81);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule